// File: doc/BRIEF.md
# Serial Configuration Register Write Slave

This block is a write-only slave on a three-wire serial port (active-low select, serial clock, serial data). It collects 32-bit command frames, shifted in most significant bit first on the rising edge of the serial clock. Each frame holds a 12-bit fixed header, then a 4-bit register address, then a 16-bit value. A frame whose header matches and whose address names one of the eight implemented registers loads its value into that register when the 32nd bit arrives. All other frames are dropped without effect.

The three serial inputs and the extended-control enable come from another clock domain. They pass through a synchronizer running on the system clock, and the slave detects serial-clock edges by oversampling. No timeout exists, so the serial clock may run as slowly as wanted. The bank drives every register value in parallel, along with the reset defaults. An initialisation tracker raises a sticky flag once all eight registers have been written. A second sticky flag reports a first write to the guarded register (address 0xD) with any value other than 0x3FFF.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset the register slots 0..7 (addresses 0x1, 0x2, 0x3, 0xA, 0xB, 0xD, 0xE, 0xF; slot k is `cfg_regs_o[16k+15:16k]`) hold 0xB0FF, 0x0000, 0x8000, 0x0000, 0x8000, 0x3FFF, 0x0000, 0x0000. `cfg_dflt_o` shows these same values. `all_written_o` and `init_err_o` are low.
- R2: A frame is 32 bits, MSB first, sampled on serial-clock rising edges while `ser_cs_n` is low: bits 31..20 header, 19..16 address, 15..0 data. A frame with header 0x001 and an implemented address loads the data into that address's slot, and no other slot changes.
- R3: A frame whose header is not exactly 0x001 changes no register.
- R4: A frame addressing an unimplemented address (0x0, 0x4..0x9, 0xC) changes no register and does not count as a write for R8.
- R5: If `ser_cs_n` rises before the 32nd bit, the partial frame is discarded. The next select-low period starts counting from bit 31 again.
- R6: While `ext_ctl_en` is low, frames are ignored and no register changes.
- R7: Bits clocked after the 32nd within the same select-low period are ignored. The frame formed by the first 32 bits is the one acted on.
- R8: `all_written_o` rises once every one of the eight slots has received at least one accepted write since reset, stays low before that, and stays high until reset.
- R9: `init_err_o` is set, and stays set until reset, if the first accepted write to address 0xD carries a value other than 0x3FFF. Later writes to 0xD of any value never set it.
- R10: A first write to 0xD with a non-0x3FFF value is still loaded into the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial port |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_ctl_en | input | 1 | Extended-control enable; the serial port is active only when high |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| cfg_regs_o | output | 128 | Current register values, slot k in bits 16k+15:16k |
| cfg_dflt_o | output | 128 | Reset default value of each slot, same layout |
| all_written_o | output | 1 | Sticky: every slot written at least once |
| init_err_o | output | 1 | Sticky: first write to 0xD was not 0x3FFF |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, eight slots with the address map and defaults of R1, and slot 5 (0xD) guarded with 0x3FFF. It drives the serial clock at one eighth of the system rate, so each serial level lasts well past the synchronizer delay. Under these settings a single run covers both the clean first write to 0xD and, after a mid-run reset, the faulty first write. It also covers frames of 20, 32 and 40 bits and the point at which the eighth distinct slot completes initialisation.

// File: rtl/cfg_ser_pkg.sv
package cfg_ser_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 4;
    localparam int HDR_W    = 12;
    localparam int NUM_REGS = 8;
    localparam int FRAME_W  = HDR_W + ADDR_W + DATA_W;

    localparam logic [HDR_W-1:0] HDR_PATTERN = 12'h001;

    // slot 0 in the low nibble
    localparam logic [NUM_REGS*ADDR_W-1:0] SLOT_ADDRS =
        {4'hF, 4'hE, 4'hD, 4'hB, 4'hA, 4'h3, 4'h2, 4'h1};

    // slot 0 in the low halfword
    localparam logic [NUM_REGS*DATA_W-1:0] SLOT_DEFAULTS =
        {16'h0000, 16'h0000, 16'h3FFF, 16'h8000,
         16'h0000, 16'h8000, 16'h0000, 16'hB0FF};

    typedef struct packed {
        logic [HDR_W-1:0]  hdr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_a,
    input  logic sclk_a,
    input  logic csn_a,
    input  logic dat_a,
    output logic en_s,
    output logic csn_s,
    output logic dat_s,
    output logic rise_s
);
    // lane order inside each stage: {en, sclk, csn, dat}
    localparam int LANES = 4;
    localparam logic [LANES-1:0] LANE_RST = 4'b0010;

    typedef struct packed {
        logic [STAGES-1:0][LANES-1:0] chain;
        logic                         sclk_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        d.chain[0] = {en_a, sclk_a, csn_a, dat_a};
        for (int i = 1; i < STAGES; i++) begin
            d.chain[i] = q.chain[i-1];
        end
        d.sclk_prev = q.chain[STAGES-1][2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.chain     <= {STAGES{LANE_RST}};
            q.sclk_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign en_s   = q.chain[STAGES-1][3];
    assign csn_s  = q.chain[STAGES-1][1];
    assign dat_s  = q.chain[STAGES-1][0];
    assign rise_s = q.chain[STAGES-1][2] & ~q.sclk_prev;
endmodule

// File: rtl/frame_rx.sv
module frame_rx
    import cfg_ser_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_s,
    input  logic          csn_s,
    input  logic          dat_s,
    input  logic          rise_s,
    output logic          done_o,
    output logic [FW-1:0] word_o,
    output logic [$clog2(FW+1)-1:0] cnt_o
);
    localparam int CNT_W = $clog2(FW + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FW - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FW);

    typedef struct packed {
        logic [FW-1:0]    sh;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (csn_s || !en_s) begin
            d.cnt = '0;
        end else if (rise_s && (q.cnt < FULL)) begin
            d.sh  = {q.sh[FW-2:0], dat_s};
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST) begin
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign word_o = q.sh;
    assign cnt_o  = q.cnt;
endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import cfg_ser_pkg::*;
#(
    parameter int                             NREG       = NUM_REGS,
    parameter logic [NUM_REGS*ADDR_W-1:0]     ADDRS      = SLOT_ADDRS,
    parameter logic [NUM_REGS*DATA_W-1:0]     DEFAULTS   = SLOT_DEFAULTS,
    parameter int                             GUARD_SLOT = 5,
    parameter logic [DATA_W-1:0]              GUARD_VAL  = 16'h3FFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit,
    input  frame_t                 frame,
    output logic [NREG*DATA_W-1:0] regs_o,
    output logic [NREG-1:0]        written_o,
    output logic                   err_o
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic [NREG-1:0]             written;
        logic                        err;
    } bank_t;

    bank_t q, d;

    logic [NREG-1:0] hit;
    logic            hdr_ok;

    assign hdr_ok = (frame.hdr == HDR_PATTERN);

    for (genvar k = 0; k < NREG; k++) begin : g_dec
        assign hit[k] = (frame.addr == ADDRS[k*ADDR_W +: ADDR_W]);
    end

    always_comb begin
        d = q;
        if (commit && hdr_ok) begin
            for (int k = 0; k < NREG; k++) begin
                if (hit[k]) begin
                    d.regs[k]    = frame.data;
                    d.written[k] = 1'b1;
                    if ((k == GUARD_SLOT) && !q.written[k] &&
                        (frame.data != GUARD_VAL)) begin
                        d.err = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.regs    <= DEFAULTS[NREG*DATA_W-1:0];
            q.written <= '0;
            q.err     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign regs_o    = q.regs;
    assign written_o = q.written;
    assign err_o     = q.err;
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfg_ser_pkg::*;
#(
    parameter int                         SYNC_STAGES = 2,
    parameter logic [NUM_REGS*ADDR_W-1:0] ADDRS       = SLOT_ADDRS,
    parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS    = SLOT_DEFAULTS,
    parameter int                         GUARD_SLOT  = 5,
    parameter logic [DATA_W-1:0]          GUARD_VAL   = 16'h3FFF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ext_ctl_en,
    input  logic                       ser_cs_n,
    input  logic                       ser_clk,
    input  logic                       ser_dat,
    output logic [NUM_REGS*DATA_W-1:0] cfg_regs_o,
    output logic [NUM_REGS*DATA_W-1:0] cfg_dflt_o,
    output logic                       all_written_o,
    output logic                       init_err_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    logic               en_s, csn_s, dat_s, rise_s;
    logic               frm_done;
    logic [FRAME_W-1:0] frm_word;
    logic [CNT_W-1:0]   frm_cnt;
    logic [NUM_REGS-1:0] written;

    ser_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_a   (ext_ctl_en),
        .sclk_a (ser_clk),
        .csn_a  (ser_cs_n),
        .dat_a  (ser_dat),
        .en_s   (en_s),
        .csn_s  (csn_s),
        .dat_s  (dat_s),
        .rise_s (rise_s)
    );

    frame_rx #(.FW(FRAME_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_s   (en_s),
        .csn_s  (csn_s),
        .dat_s  (dat_s),
        .rise_s (rise_s),
        .done_o (frm_done),
        .word_o (frm_word),
        .cnt_o  (frm_cnt)
    );

    reg_bank #(
        .NREG       (NUM_REGS),
        .ADDRS      (ADDRS),
        .DEFAULTS   (DEFAULTS),
        .GUARD_SLOT (GUARD_SLOT),
        .GUARD_VAL  (GUARD_VAL)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (frm_done),
        .frame     (frame_t'(frm_word)),
        .regs_o    (cfg_regs_o),
        .written_o (written),
        .err_o     (init_err_o)
    );

    assign cfg_dflt_o    = DEFAULTS;
    assign all_written_o = &written;
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk
    import cfg_ser_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       commit,
    input logic [FRAME_W-1:0]         word,
    input logic [$clog2(FRAME_W+1)-1:0] cnt,
    input logic                       csn_s,
    input logic                       en_s,
    input logic [NUM_REGS*DATA_W-1:0] regs,
    input logic                       all_written,
    input logic                       init_err
);
    // registers move only in the cycle after a completed frame
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(regs));

    p_bad_header_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (word[FRAME_W-1 -: HDR_W] != HDR_PATTERN)) |=> $stable(regs));

    p_cs_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (cnt == '0));

    p_disabled_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> !commit);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= ($clog2(FRAME_W+1))'(FRAME_W));

    p_all_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        all_written |=> all_written);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |=> init_err);
endmodule

bind cfg_serial_slave cfg_serial_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (frm_done),
    .word        (frm_word),
    .cnt         (frm_cnt),
    .csn_s       (csn_s),
    .en_s        (en_s),
    .regs        (cfg_regs_o),
    .all_written (all_written_o),
    .init_err    (init_err_o)
);

// File: tb/sim_cfg_serial_slave.sv
module sim_cfg_serial_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_ctl_en = 1'b1;
    logic ser_cs_n = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic [127:0] cfg_regs_o, cfg_dflt_o;
    logic all_written_o, init_err_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_regs [8];
    logic [3:0]  slot_addr [8];

    always #10 clk = ~clk;

    cfg_serial_slave u0 (
        .clk(clk), .rst_n(rst_n), .ext_ctl_en(ext_ctl_en),
        .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .cfg_regs_o(cfg_regs_o), .cfg_dflt_o(cfg_dflt_o),
        .all_written_o(all_written_o), .init_err_o(init_err_o)
    );

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_defaults();
        exp_regs[0] = 16'hB0FF; exp_regs[1] = 16'h0000;
        exp_regs[2] = 16'h8000; exp_regs[3] = 16'h0000;
        exp_regs[4] = 16'h8000; exp_regs[5] = 16'h3FFF;
        exp_regs[6] = 16'h0000; exp_regs[7] = 16'h0000;
    endtask

    task automatic chk_bank(input string req);
        for (int k = 0; k < 8; k++) begin
            chk(req, {16'h0, cfg_regs_o[k*16 +: 16]}, {16'h0, exp_regs[k]});
        end
    endtask

    // shifts the top n bits of 'bits' MSB first, then releases select
    task automatic shift(input logic [63:0] bits, input int n);
        @(negedge clk);
        ser_cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < n; i++) begin
            ser_dat = bits[63 - i];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        wait_clk(8);
        ser_cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic frame(input logic [11:0] hdr, input logic [3:0] a,
                         input logic [15:0] v, input int n);
        shift({hdr, a, v, 32'hFFFF_FFFF}, n);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        set_defaults();
    endtask

    task automatic t_reset();
        chk_bank("R1 reset value");
        chk("R1 defaults out", {16'h0, cfg_dflt_o[5*16 +: 16]}, 32'h3FFF);
        chk("R1 defaults out", {16'h0, cfg_dflt_o[0 +: 16]}, 32'hB0FF);
        chk("R1 all_written", {31'h0, all_written_o}, 32'h0);
        chk("R1 init_err", {31'h0, init_err_o}, 32'h0);
    endtask

    task automatic t_good_write();
        frame(12'h001, 4'h2, 16'h1A5C, 32);
        exp_regs[1] = 16'h1A5C;
        chk_bank("R2 valid frame");
        frame(12'h001, 4'hD, 16'h3FFF, 32);
        chk_bank("R2 guarded write");
        chk("R9 clean first write", {31'h0, init_err_o}, 32'h0);
        frame(12'h001, 4'hD, 16'h1234, 32);
        exp_regs[5] = 16'h1234;
        chk_bank("R2 second write");
        chk("R9 later write no err", {31'h0, init_err_o}, 32'h0);
    endtask

    task automatic t_bad_header();
        frame(12'h003, 4'h3, 16'hDEAD, 32);
        chk_bank("R3 header 003");
        frame(12'h000, 4'h1, 16'hBEEF, 32);
        chk_bank("R3 header 000");
        frame(12'h801, 4'hA, 16'hCAFE, 32);
        chk_bank("R3 header 801");
    endtask

    task automatic t_bad_addr();
        frame(12'h001, 4'h0, 16'h5555, 32);
        frame(12'h001, 4'h5, 16'h6666, 32);
        frame(12'h001, 4'hC, 16'h7777, 32);
        chk_bank("R4 unimplemented address");
    endtask

    task automatic t_short();
        shift({12'h001, 4'h3, 16'h4321, 32'h0}, 20);
        chk_bank("R5 short frame");
        frame(12'h001, 4'h3, 16'h0ABC, 32);
        exp_regs[2] = 16'h0ABC;
        chk_bank("R5 fresh count after short");
    endtask

    task automatic t_disabled();
        ext_ctl_en = 1'b0;
        wait_clk(4);
        frame(12'h001, 4'hA, 16'h9999, 32);
        chk_bank("R6 disabled");
        ext_ctl_en = 1'b1;
        wait_clk(4);
    endtask

    task automatic t_long();
        frame(12'h001, 4'hA, 16'h0F0F, 40);
        exp_regs[3] = 16'h0F0F;
        chk_bank("R7 extra bits ignored");
    endtask

    task automatic t_all_written();
        // written so far: 0x2, 0xD, 0x3, 0xA
        frame(12'h001, 4'h1, 16'h00B1, 32); exp_regs[0] = 16'h00B1;
        frame(12'h001, 4'hB, 16'h0123, 32); exp_regs[4] = 16'h0123;
        frame(12'h001, 4'hE, 16'h0E0E, 32); exp_regs[6] = 16'h0E0E;
        chk("R8 not yet all", {31'h0, all_written_o}, 32'h0);
        frame(12'h001, 4'hF, 16'hF00F, 32); exp_regs[7] = 16'hF00F;
        chk("R8 all written", {31'h0, all_written_o}, 32'h1);
        chk_bank("R8 bank contents");
        frame(12'h001, 4'h2, 16'h2222, 32); exp_regs[1] = 16'h2222;
        chk("R8 sticky", {31'h0, all_written_o}, 32'h1);
    endtask

    task automatic t_bad_first_guard();
        do_reset();
        chk_bank("R1 after second reset");
        chk("R8 cleared by reset", {31'h0, all_written_o}, 32'h0);
        frame(12'h001, 4'hD, 16'h0042, 32);
        exp_regs[5] = 16'h0042;
        chk("R9 bad first write", {31'h0, init_err_o}, 32'h1);
        chk_bank("R10 value loaded");
        frame(12'h001, 4'hD, 16'h3FFF, 32);
        exp_regs[5] = 16'h3FFF;
        chk("R9 err sticky", {31'h0, init_err_o}, 32'h1);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        set_defaults();
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_good_write();
        t_bad_header();
        t_bad_addr();
        t_short();
        t_disabled();
        t_long();
        t_all_written();
        t_bad_first_guard();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule